// File: doc/BRIEF.md
# Three-Trit Packer to Five-Bit Code

This block packs three balanced ternary digits into a five-bit code. Each digit arrives as a two-bit pair: 00 means zero, 01 means plus one, 11 means minus one, and 10 is not a legal pair. Three digits carry 27 values, so five bits are enough in place of six. The code is built so that a small companion unpacking circuit can recover the digits with very few gates. Software or hardware uses the packer to fill a weight memory with dense codes, and the unpacking side reads that memory continuously.

The packer is purely combinational. It first sorts the input by which digits are zero. The low two code bits name that class. The upper three bits then carry signs, or a magnitude, in the slots the unpacking side expects. Where the unpacking side ignores a bit, the packer drives a fixed value. An illegal pair anywhere on the input raises a flag and forces the code to zero.

Top module: `ternary_pack5`

## Requirements
- R1: Bits: the top digit is trits_i[5:4], the middle digit is [3:2] and the bottom digit is [1:0]. If all three digits are non-zero, code_o[1:0] = 11. code_o[4], [3] and [2] are then the sign bits of the top, middle and bottom digits, where 1 means negative.
- R2: If the top digit is zero and the middle digit is non-zero, code_o[1:0] = 00. code_o[4] is 1 exactly when the bottom digit is non-zero, code_o[3] is the middle sign, and code_o[2] is the bottom sign.
- R3: If the middle digit is zero and the bottom digit is non-zero, code_o[1:0] = 10. code_o[3] is 1 exactly when the top digit is non-zero, code_o[4] is the top sign, and code_o[2] is the bottom sign.
- R4: Every other legal input has a zero bottom digit and uses code_o[1:0] = 01. In that class, code_o[4] is the top sign.
  - If both the top and middle digits are non-zero, code_o[2] = 1 and code_o[3] is the middle sign.
  - If only the top digit is non-zero, code_o[3:2] = 10.
  - If all three digits are zero, code_o[3:2] = 00.
- R5: With the default fill parameter, every code bit that the unpacking side ignores is driven to 0. This covers a sign bit whose digit is zero. The all-zero input therefore gives 00001, and a lone middle plus one gives 00000.
- R6: If any input pair equals 10, illegal_o is 1 and code_o is 00000. Otherwise illegal_o is 0.
- R7: The 27 legal inputs give 27 distinct codes. Unpacking each code by the class rules of R1 to R4 gives back the input exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| trits_i | input | 6 | Three digit pairs, top digit in [5:4] |
| code_o | output | 5 | Packed code: class in [1:0], payload in [4:2] |
| illegal_o | output | 1 | High when any input pair is 10 |

## Verification
Two functions can act on the same input: the illegal-pair override and the class encoding. The bench provokes this by placing a 10 pair in each digit position while the other two digits are non-zero, so that without the override the input would encode as a full class. The result is judged correct only if the flag is high and the code is all zeros, not a class code. The same collision is swept over all 37 illegal patterns of the six-bit input space.

// File: rtl/ternary_pack5_pkg.sv
package ternary_pack5_pkg;

  localparam int unsigned DIGITS   = 3;
  localparam int unsigned PAIR_W   = 2;
  localparam int unsigned IN_W     = DIGITS * PAIR_W;
  localparam int unsigned CODE_W   = 5;
  localparam int unsigned GRP_W    = 2;
  localparam int unsigned LOAD_W   = CODE_W - GRP_W;

  typedef enum logic [GRP_W-1:0] {
    GRP_TOPZ = 2'b00,
    GRP_REST = 2'b01,
    GRP_MIDZ = 2'b10,
    GRP_FULL = 2'b11
  } grp_e;

  typedef struct packed {
    logic bad;
    logic nz;
    logic neg;
  } digit_t;

  // Pair decode: 00 zero, 01 plus, 11 minus, 10 illegal.
  function automatic digit_t classify(input logic [PAIR_W-1:0] p);
    digit_t d;
    d.bad = p[1] & ~p[0];
    d.nz  = p[0];
    d.neg = p[1] & p[0];
    return d;
  endfunction

endpackage

// File: rtl/ternary_pack5_slice.sv
module ternary_pack5_slice
  import ternary_pack5_pkg::*;
(
  input  logic [PAIR_W-1:0] pair_i,
  output digit_t            dig_o
);
  always_comb dig_o = classify(pair_i);
endmodule

// File: rtl/ternary_pack5_group.sv
module ternary_pack5_group
  import ternary_pack5_pkg::*;
(
  input  digit_t top_i,
  input  digit_t mid_i,
  input  digit_t bot_i,
  output grp_e   grp_o
);
  always_comb begin
    if (top_i.nz && mid_i.nz && bot_i.nz) grp_o = GRP_FULL;
    else if (!top_i.nz && mid_i.nz)       grp_o = GRP_TOPZ;
    else if (!mid_i.nz && bot_i.nz)       grp_o = GRP_MIDZ;
    else                                  grp_o = GRP_REST;
  end
endmodule

// File: rtl/ternary_pack5_fill.sv
module ternary_pack5_fill
  import ternary_pack5_pkg::*;
#(
  parameter logic FILL = 1'b0
) (
  input  grp_e               grp_i,
  input  digit_t             top_i,
  input  digit_t             mid_i,
  input  digit_t             bot_i,
  output logic [LOAD_W-1:0]  load_o
);
  logic top_s, mid_s, bot_s;

  // Signs of zero digits are free slots for the unpacker.
  always_comb begin
    top_s = top_i.nz ? top_i.neg : FILL;
    mid_s = mid_i.nz ? mid_i.neg : FILL;
    bot_s = bot_i.nz ? bot_i.neg : FILL;
  end

  always_comb begin
    unique case (grp_i)
      GRP_FULL: load_o = {top_s, mid_s, bot_s};
      GRP_TOPZ: load_o = {bot_i.nz, mid_s, bot_s};
      GRP_MIDZ: load_o = {top_s, top_i.nz, bot_s};
      default: begin
        if (mid_i.nz)      load_o = {top_s, mid_s, 1'b1};
        else if (top_i.nz) load_o = {top_s, 1'b1, 1'b0};
        else               load_o = {FILL, 1'b0, 1'b0};
      end
    endcase
  end
endmodule

// File: rtl/ternary_pack5.sv
module ternary_pack5
  import ternary_pack5_pkg::*;
#(
  parameter logic FILL = 1'b0
) (
  input  logic [5:0] trits_i,
  output logic [4:0] code_o,
  output logic       illegal_o
);
  digit_t [DIGITS-1:0] dig;
  grp_e                grp_sel;
  logic [LOAD_W-1:0]   load;
  logic                any_bad;

  for (genvar g = 0; g < DIGITS; g++) begin : g_slice
    ternary_pack5_slice slice_i (
      .pair_i (trits_i[g*PAIR_W +: PAIR_W]),
      .dig_o  (dig[g])
    );
  end

  ternary_pack5_group group_i (
    .top_i (dig[2]),
    .mid_i (dig[1]),
    .bot_i (dig[0]),
    .grp_o (grp_sel)
  );

  ternary_pack5_fill #(.FILL(FILL)) fill_i (
    .grp_i  (grp_sel),
    .top_i  (dig[2]),
    .mid_i  (dig[1]),
    .bot_i  (dig[0]),
    .load_o (load)
  );

  always_comb begin
    any_bad = 1'b0;
    for (int k = 0; k < DIGITS; k++) any_bad |= dig[k].bad;
  end

  assign illegal_o = any_bad;
  assign code_o    = any_bad ? '0 : {load, grp_sel};

endmodule

// File: rtl/ternary_pack5_chk.sv
module ternary_pack5_chk
  import ternary_pack5_pkg::*;
(
  input logic [5:0] trits_i,
  input logic [4:0] code_o,
  input logic       illegal_o,
  input grp_e       grp_sel
);
  logic legal, t_nz, m_nz, b_nz;

  always_comb begin
    legal = (trits_i[5:4] != 2'b10) && (trits_i[3:2] != 2'b10) && (trits_i[1:0] != 2'b10);
    t_nz  = trits_i[4];
    m_nz  = trits_i[2];
    b_nz  = trits_i[0];
  end

  always_comb begin
    p_err_zero_r6: assert (!illegal_o || code_o == 5'd0);
    p_err_flag_r6: assert (illegal_o == !legal);
    p_full_grp_r1: assert (!(legal && t_nz && m_nz && b_nz) || grp_sel == GRP_FULL);
    p_topz_r2:     assert (!(legal && !t_nz && m_nz) || (code_o[1:0] == 2'b00 && code_o[4] == b_nz));
    p_midz_r3:     assert (!(legal && !m_nz && b_nz) || (code_o[1:0] == 2'b10 && code_o[3] == t_nz));
    p_rest_r4:     assert (!(legal && !b_nz && !(!t_nz && m_nz)) || code_o[1:0] == 2'b01);
    p_zero_r5:     assert (!(trits_i == 6'd0) || code_o == 5'b00001);
  end
endmodule

bind ternary_pack5 ternary_pack5_chk chk_i (
  .trits_i   (trits_i),
  .code_o    (code_o),
  .illegal_o (illegal_o),
  .grp_sel   (grp_sel)
);

// File: tb/ternary_pack5_tb_top.sv
module ternary_pack5_tb_top;

  logic       clk = 1'b0;
  logic [5:0] trits;
  logic [4:0] code;
  logic       illegal;
  int         checks = 0;
  int         errors = 0;
  logic [31:0] seen = '0;
  bit         finished = 1'b0;

  typedef struct {
    logic [5:0] t;
    logic [4:0] exp_code;
    logic       exp_err;
  } item_t;

  item_t sb_q[$];

  always #2 clk = ~clk;

  ternary_pack5 dut_i (
    .trits_i   (trits),
    .code_o    (code),
    .illegal_o (illegal)
  );

  function automatic int dval(input logic [1:0] p);
    if (p == 2'b01) return 1;
    if (p == 2'b11) return -1;
    return 0;
  endfunction

  // Expected code from the class rules (R1..R5).
  function automatic logic [4:0] ref_code(input logic [5:0] t);
    int a, b, c;
    a = dval(t[5:4]); b = dval(t[3:2]); c = dval(t[1:0]);
    if (a != 0 && b != 0 && c != 0) return {a < 0, b < 0, c < 0, 2'b11};
    if (a == 0 && b != 0)           return {c != 0, b < 0, c < 0, 2'b00};
    if (b == 0 && c != 0)           return {a < 0, a != 0, c < 0, 2'b10};
    if (b != 0)                     return {a < 0, b < 0, 1'b1, 2'b01};
    if (a != 0)                     return {a < 0, 2'b10, 2'b01};
    return 5'b00001;
  endfunction

  function automatic logic [1:0] mk(input logic nz, input logic neg);
    return nz ? {neg, 1'b1} : 2'b00;
  endfunction

  // Independent unpacker model (R7).
  function automatic logic [5:0] unpack(input logic [4:0] c);
    case (c[1:0])
      2'b11: return {mk(1, c[4]), mk(1, c[3]), mk(1, c[2])};
      2'b00: return {2'b00, mk(1, c[3]), mk(c[4], c[2])};
      2'b10: return {mk(c[3], c[4]), 2'b00, mk(1, c[2])};
      default:
        if (c[2]) return {mk(1, c[4]), mk(1, c[3]), 2'b00};
        else      return {mk(c[3], c[4]), 4'b0000};
    endcase
  endfunction

  function automatic string req_of(input logic [5:0] t);
    int a, b, c;
    if (t[5:4] == 2'b10 || t[3:2] == 2'b10 || t[1:0] == 2'b10) return "R6";
    a = dval(t[5:4]); b = dval(t[3:2]); c = dval(t[1:0]);
    if (a != 0 && b != 0 && c != 0) return "R1";
    if (a == 0 && b != 0)           return "R2";
    if (b == 0 && c != 0)           return "R3";
    return "R4";
  endfunction

  task automatic drive(input logic [5:0] t);
    item_t it;
    @(negedge clk);
    trits = t;
    it.t = t;
    it.exp_err = (req_of(t) == "R6");
    it.exp_code = it.exp_err ? 5'd0 : ref_code(t);
    sb_q.push_back(it);
  endtask

  // Monitor: sampled at posedge, inputs were driven at negedge.
  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      string rq;
      it = sb_q.pop_front();
      rq = req_of(it.t);
      checks++;
      if (code !== it.exp_code || illegal !== it.exp_err) begin
        errors++;
        $display("FAIL %s (R5 fill) in=%b code=%b err=%b exp code=%b err=%b",
                 rq, it.t, code, illegal, it.exp_code, it.exp_err);
      end
      if (!it.exp_err) begin
        checks++;
        if (unpack(code) !== it.t) begin
          errors++;
          $display("FAIL R7 roundtrip in=%b code=%b got=%b exp=%b", it.t, code, unpack(code), it.t);
        end
        checks++;
        if (seen[code]) begin
          errors++;
          $display("FAIL R7 duplicate code=%b in=%b exp=unique", code, it.t);
        end
        seen[code] = 1'b1;
      end
    end
  end

  initial begin
    trits = 6'd0;
    #1;
    checks++;
    if (code !== 5'b00001 || illegal !== 1'b0) begin
      errors++;
      $display("FAIL R5 initial code=%b err=%b exp code=00001 err=0", code, illegal);
    end
    // R6 collision first: illegal pair among non-zero digits.
    drive(6'b100101);
    drive(6'b011001);
    drive(6'b111110);
    drive(6'b101010);
    // R1..R7 exhaustive sweep of the six-bit input space.
    for (int i = 0; i < 64; i++) drive(i[5:0]);
    while (sb_q.size() > 0) @(posedge clk);
    @(negedge clk);
    checks++;
    if ($countones(seen) != 27) begin
      errors++;
      $display("FAIL R7 distinct codes=%0d exp=27", $countones(seen));
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R7 got=timeout exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule